// File: doc/BRIEF.md
# Linked Ping-Pong Block DMA Channel

This block is a single DMA channel that drains a peripheral sample FIFO into two memory buffers in turn. Two parameter sets, A and B, each describe one block: a source address, a destination address, an element count, a source stride, a destination stride and a link field. When a block ends, the channel reloads whichever set the link names and carries on. With A linked to B and B linked to A, one buffer fills while the processor works on the other, and the processor does nothing to switch buffers.

Each element moves in four steps. The channel waits for the peripheral request. It then reads the source address and writes the value it read to the destination address. Only after that write is accepted does it acknowledge the peripheral. Both addresses then step by their own signed byte stride. A source stride of 0 keeps the FIFO address fixed. A destination stride of 2 writes 16-bit samples contiguously, and a larger stride skips rows of a 2-D array.

At the end of each block the channel sets a sticky completion bit for the set that finished and records which set that was. Software clears a completion bit by writing 1 to it.

Register map (write-only):

| Address | Meaning |
|---|---|
| 0 to 5 | Set A: src, dst, count, src stride, dst stride, link |
| 8 to 13 | Set B, same field order |
| 6 | Control: bit0 = start, bit1 = starting set |
| 7 | Completion clear: bit0 = A, bit1 = B |

FSM states and transitions:

- IDLE -> LOAD on start.
- LOAD copies the selected set and goes to WAIT, or to DONE if the count is 0.
- WAIT -> READ when the request is high.
- READ -> WRITE on memory acknowledge.
- WRITE -> STEP on memory acknowledge.
- STEP pulses the peripheral acknowledge and steps the addresses. It goes to DONE after the last element and to WAIT otherwise.
- DONE raises the completion bit. It goes to LOAD for the linked set, or to IDLE when the link is all-ones.

Top module: `pingpong_dma`

## Requirements
- R1: After reset the channel is idle (busy 0), mem_req and per_ack are 0, both completion bits are 0 and last_set is 0.
- R2: For each element the channel reads the source address, then writes the same data to the destination address. It gives exactly one per_ack pulse per element, in the cycle after the write is accepted.
- R3: After each element, the source address advances by the source stride and the destination address by the destination stride, in bytes modulo 2^16. A stride of 0 keeps the address constant.
- R4: A block moves exactly `count` elements. At its end, completion bit 0 (set A) or bit 1 (set B) is set and last_set shows that set (0 = A, 1 = B).
- R5: At block end, a link value of 0 or 1 reloads set A or set B, and the next block runs with no register access.
- R6: A link value of 2'b11 stops the channel after the current block (busy falls).
- R7: Completion bits are sticky. Writing 1 to bit n of address 7 clears bit n, and writing 0 leaves it unchanged.
- R8: No element starts while per_req is low. A request that stays high through a stalled write is served, and no sample is lost or repeated.
- R9: Parameter set fields are taken at block load. Set A lives at addresses 0 to 5 and set B at 8 to 13, each as src, dst, count, src stride, dst stride, link.
- R10: A count of 0 completes the block at once with no memory access and sets its completion bit.
- R11: Writing address 6 with bit0 = 1 starts the channel with the set chosen by bit1 (0 = A, 1 = B). The write is ignored while the channel is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| per_req | input | 1 | Peripheral has a sample ready (level) |
| per_ack | output | 1 | One-cycle pulse: sample consumed |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data |
| mem_ack | input | 1 | Memory accepted the request this cycle |
| busy | output | 1 | Channel active |
| done_irq | output | 2 | Sticky completion bits (bit0 A, bit1 B) |
| last_set | output | 1 | Set of the most recently finished block |

## Verification
The hardest case to reach from the ports is a set change that happens while the peripheral request stays high and memory writes stall. A lost or repeated sample there would only show in the data sequence.

The bench holds per_req high and lets memory acknowledge only every third cycle, then runs A to B to A to B. It waits for the first B completion and rewrites B's link to all-ones while the second A block is running. This also shows that link changes take effect only at the next load.

The sequence numbers written then have to climb without gaps across all four blocks and both buffers.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
    localparam int REG_W  = 16;
    localparam int LINK_W = 2;
    localparam int NSETS  = 2;
    localparam logic [LINK_W-1:0] LINK_STOP = '1;
    localparam logic [3:0] RA_CTRL = 4'h6;
    localparam logic [3:0] RA_CLR  = 4'h7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_STEP,
        ST_DONE
    } dma_state_e;

    typedef struct packed {
        logic [REG_W-1:0]  src;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  cnt;
        logic [REG_W-1:0]  sstr;
        logic [REG_W-1:0]  dstr;
        logic [LINK_W-1:0] link;
    } pset_t;
endpackage

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
    import pp_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              busy,
    input  logic              done_pulse,
    input  logic              done_set,
    output pset_t             sets [NSETS],
    output logic              start,
    output logic              start_set,
    output logic [NSETS-1:0]  done_irq
);
    logic clr_hit;

    assign clr_hit   = cfg_we && (cfg_addr == RA_CLR);
    // R11: start only accepted while idle
    assign start     = cfg_we && (cfg_addr == RA_CTRL) && cfg_wdata[0] && !busy;
    assign start_set = cfg_wdata[1];

    for (genvar g = 0; g < NSETS; g++) begin : g_set
        localparam logic SEL = 1'(g);
        logic wr_hit;
        assign wr_hit = cfg_we && (cfg_addr[3] == SEL);

        // R9: field decode within one set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sets[g] <= '{src: '0, dst: '0, cnt: '0, sstr: '0, dstr: '0, link: LINK_STOP};
            end else if (wr_hit) begin
                case (cfg_addr[2:0])
                    3'd0:    sets[g].src  <= cfg_wdata;
                    3'd1:    sets[g].dst  <= cfg_wdata;
                    3'd2:    sets[g].cnt  <= cfg_wdata;
                    3'd3:    sets[g].sstr <= cfg_wdata;
                    3'd4:    sets[g].dstr <= cfg_wdata;
                    3'd5:    sets[g].link <= cfg_wdata[LINK_W-1:0];
                    default: ;
                endcase
            end
        end

        // R7: sticky completion bit, write-1-to-clear, set wins
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                done_irq[g] <= 1'b0;
            else if (done_pulse && (done_set == SEL))
                done_irq[g] <= 1'b1;
            else if (clr_hit && cfg_wdata[g])
                done_irq[g] <= 1'b0;
        end

        assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (done_irq[g] && !(clr_hit && cfg_wdata[g])) |=> done_irq[g]);
    end
endmodule

// File: rtl/pp_dma_addr_gen.sv
module pp_dma_addr_gen
    import pp_dma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  pset_t              load_set,
    input  logic               step,
    output logic [REG_W-1:0]   cur_src,
    output logic [REG_W-1:0]   cur_dst,
    output logic               last_elem,
    output logic [LINK_W-1:0]  cur_link
);
    logic [REG_W-1:0] left;
    logic [REG_W-1:0] sstr_q;
    logic [REG_W-1:0] dstr_q;

    assign last_elem = (left == REG_W'(1));

    // R3, R9: working copy taken at load, stepped per element
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_src  <= '0;
            cur_dst  <= '0;
            left     <= '0;
            sstr_q   <= '0;
            dstr_q   <= '0;
            cur_link <= LINK_STOP;
        end else if (load) begin
            cur_src  <= load_set.src;
            cur_dst  <= load_set.dst;
            left     <= load_set.cnt;
            sstr_q   <= load_set.sstr;
            dstr_q   <= load_set.dstr;
            cur_link <= load_set.link;
        end else if (step) begin
            cur_src  <= cur_src + sstr_q;
            cur_dst  <= cur_dst + dstr_q;
            left     <= left - REG_W'(1);
        end
    end

    assert_no_underrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (left != '0));
endmodule

// File: rtl/pp_dma_fsm.sv
module pp_dma_fsm
    import pp_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_set,
    input  logic              per_req,
    input  logic              mem_ack,
    input  logic              cnt_zero,
    input  logic              last_elem,
    input  logic [LINK_W-1:0] cur_link,
    output logic              load,
    output logic              step,
    output logic              done_pulse,
    output logic              mem_req,
    output logic              mem_we,
    output logic              per_ack,
    output logic              rd_capture,
    output logic              busy,
    output logic              cur_set,
    output logic              last_set
);
    dma_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_set  <= 1'b0;
            last_set <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start)
                cur_set <= start_set;
            if (state == ST_DONE) begin
                last_set <= cur_set;
                if (cur_link != LINK_STOP)
                    cur_set <= cur_link[0];
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)   state_nx = ST_LOAD;
            ST_LOAD:  state_nx = cnt_zero ? ST_DONE : ST_WAIT;
            ST_WAIT:  if (per_req) state_nx = ST_READ;
            ST_READ:  if (mem_ack) state_nx = ST_WRITE;
            ST_WRITE: if (mem_ack) state_nx = ST_STEP;
            ST_STEP:  state_nx = last_elem ? ST_DONE : ST_WAIT;
            ST_DONE:  state_nx = (cur_link == LINK_STOP) ? ST_IDLE : ST_LOAD;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load       = (state == ST_LOAD);
        step       = (state == ST_STEP);
        per_ack    = (state == ST_STEP);
        done_pulse = (state == ST_DONE);
        mem_req    = (state == ST_READ) || (state == ST_WRITE);
        mem_we     = (state == ST_WRITE);
        rd_capture = (state == ST_READ) && mem_ack;
        busy       = (state != ST_IDLE);
    end

    assert_ack_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |-> $past(mem_req && mem_we && mem_ack));
    assert_wait_for_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !per_req) |=> !mem_req);
endmodule

// File: rtl/pingpong_dma.sv
module pingpong_dma
    import pp_dma_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              per_req,
    output logic              per_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [REG_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic [NSETS-1:0]  done_irq,
    output logic              last_set
);
    pset_t             sets [NSETS];
    logic              start, start_set;
    logic              load, step, done_pulse, rd_capture;
    logic              cur_set, last_elem;
    logic [REG_W-1:0]  cur_src, cur_dst;
    logic [LINK_W-1:0] cur_link;
    logic [DATA_W-1:0] rd_buf;
    logic              cnt_zero;

    assign cnt_zero = (sets[cur_set].cnt == '0);

    pp_dma_regs i_regs (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
        .busy, .done_pulse, .done_set(cur_set),
        .sets, .start, .start_set, .done_irq
    );

    pp_dma_addr_gen i_addr (
        .clk, .rst_n, .load, .load_set(sets[cur_set]), .step,
        .cur_src, .cur_dst, .last_elem, .cur_link
    );

    pp_dma_fsm i_fsm (
        .clk, .rst_n, .start, .start_set, .per_req, .mem_ack,
        .cnt_zero, .last_elem, .cur_link,
        .load, .step, .done_pulse, .mem_req, .mem_we, .per_ack,
        .rd_capture, .busy, .cur_set, .last_set
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          rd_buf <= '0;
        else if (rd_capture) rd_buf <= mem_rdata;
    end

    assign mem_addr  = mem_we ? cur_dst : cur_src;
    assign mem_wdata = rd_buf;

    assert_hold_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    assert_irq_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> done_irq[$past(cur_set)]);
    assert_stop_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && cur_link == LINK_STOP) |=> !busy);
    assert_reload_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && cur_link != LINK_STOP) |=> busy);
endmodule

// File: tb/test_pingpong_dma.sv
`timescale 1ns/1ps
module test_pingpong_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        per_req = 1'b0;
    logic        per_ack, mem_req, mem_we, mem_ack, busy, last_set;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  done_irq;

    logic        mem_rdy = 1'b1;
    logic        stall_mode = 1'b0;
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    int          nwr = 0;
    int          nrd = 0;
    int          nack = 0;
    logic [15:0] sample_val = 16'h0;
    logic [15:0] waddr [256];
    logic [15:0] wdat  [256];
    logic [15:0] raddr [256];

    always #2.5 clk = ~clk;

    pingpong_dma i_pingpong_dma (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .per_req, .per_ack,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack,
        .busy, .done_irq, .last_set
    );

    assign mem_ack   = mem_req & mem_rdy;
    assign mem_rdata = sample_val;

    always @(negedge clk) begin
        cyc     <= cyc + 1;
        mem_rdy <= stall_mode ? (cyc % 3 == 0) : 1'b1;
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack && mem_we) begin
            waddr[nwr % 256] <= mem_addr;
            wdat[nwr % 256]  <= mem_wdata;
            nwr <= nwr + 1;
        end
        if (mem_req && mem_ack && !mem_we) begin
            raddr[nrd % 256] <= mem_addr;
            nrd <= nrd + 1;
        end
        if (per_ack) begin
            sample_val <= sample_val + 16'h1;
            nack <= nack + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog_set(input int s, input logic [15:0] src, input logic [15:0] dst,
                            input logic [15:0] cnt, input logic [15:0] ss,
                            input logic [15:0] ds, input logic [15:0] lnk);
        logic [3:0] b;
        b = (s != 0) ? 4'h8 : 4'h0;
        cfg_write(b + 4'd0, src);
        cfg_write(b + 4'd1, dst);
        cfg_write(b + 4'd2, cnt);
        cfg_write(b + 4'd3, ss);
        cfg_write(b + 4'd4, ds);
        cfg_write(b + 4'd5, lnk);
    endtask

    task automatic wait_idle(input string tag);
        int n;
        n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(!busy, {tag, " timeout"}, busy, 0);
    endtask

    task automatic test_reset();
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
        check(per_ack == 1'b0, "R1 per_ack", per_ack, 0);
        check(done_irq == 2'b00, "R1 done_irq", done_irq, 0);
        check(last_set == 1'b0, "R1 last_set", last_set, 0);
    endtask

    task automatic test_single_block();
        int wb, rb, ab;
        logic [15:0] s0;
        per_req = 1'b1;
        prog_set(0, 16'h4000, 16'h1000, 16'd4, 16'd0, 16'd2, 16'h3);
        wb = nwr; rb = nrd; ab = nack; s0 = sample_val;
        cfg_write(4'h6, 16'h1);
        wait_idle("R6 single");
        check(nwr - wb == 4, "R4 element count", nwr - wb, 4);
        check(nack - ab == 4, "R2 per_ack count", nack - ab, 4);
        for (int k = 0; k < 4; k++) begin
            check(waddr[(wb + k) % 256] == 16'h1000 + 16'(2 * k), "R3 dst step",
                  waddr[(wb + k) % 256], 16'h1000 + 2 * k);
            check(raddr[(rb + k) % 256] == 16'h4000, "R3 src stride 0",
                  raddr[(rb + k) % 256], 16'h4000);
            check(wdat[(wb + k) % 256] == s0 + 16'(k), "R2 data copy",
                  wdat[(wb + k) % 256], s0 + k);
        end
        check(done_irq == 2'b01, "R4 done bit A", done_irq, 1);
        check(last_set == 1'b0, "R4 last_set A", last_set, 0);
        check(busy == 1'b0, "R6 stopped", busy, 0);
    endtask

    task automatic test_pingpong_stall();
        int wb, n;
        logic [15:0] s0, ea;
        cfg_write(4'h7, 16'h3);
        prog_set(0, 16'h4000, 16'h1000, 16'd3, 16'd0, 16'd2, 16'h1);
        prog_set(1, 16'h4000, 16'h2000, 16'd3, 16'd0, 16'd2, 16'h0);
        per_req = 1'b1;
        stall_mode = 1'b1;
        wb = nwr; s0 = sample_val;
        cfg_write(4'h6, 16'h1);
        n = 0;
        while (!done_irq[1] && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(busy == 1'b1, "R5 still running after B", busy, 1);
        // Link change takes effect at B's next load
        cfg_write(4'hD, 16'h3);
        cfg_write(4'h7, 16'h3);
        wait_idle("R5 pingpong");
        stall_mode = 1'b0;
        check(nwr - wb == 12, "R5 four blocks", nwr - wb, 12);
        for (int k = 0; k < 12; k++) begin
            ea = (((k / 3) % 2) != 0) ? 16'h2000 : 16'h1000;
            ea = ea + 16'(2 * (k % 3));
            check(waddr[(wb + k) % 256] == ea, "R5 alternating buffer",
                  waddr[(wb + k) % 256], ea);
            check(wdat[(wb + k) % 256] == s0 + 16'(k), "R8 no sample lost",
                  wdat[(wb + k) % 256], s0 + k);
        end
        check(done_irq == 2'b11, "R4 both done", done_irq, 3);
        check(last_set == 1'b1, "R4 last_set B", last_set, 1);
    endtask

    task automatic test_row_skip();
        int wb, rb;
        cfg_write(4'h7, 16'h3);
        prog_set(1, 16'h5000, 16'h3000, 16'd3, 16'd2, 16'd8, 16'h3);
        per_req = 1'b1;
        wb = nwr; rb = nrd;
        cfg_write(4'h6, 16'h3);
        wait_idle("R11 start B");
        for (int k = 0; k < 3; k++) begin
            check(waddr[(wb + k) % 256] == 16'h3000 + 16'(8 * k), "R3 row skip dst",
                  waddr[(wb + k) % 256], 16'h3000 + 8 * k);
            check(raddr[(rb + k) % 256] == 16'h5000 + 16'(2 * k), "R3 src stride",
                  raddr[(rb + k) % 256], 16'h5000 + 2 * k);
        end
        check(done_irq == 2'b10, "R11 set B done", done_irq, 2);
        check(last_set == 1'b1, "R11 last_set B", last_set, 1);
    endtask

    task automatic test_count_zero();
        int wb, rb;
        prog_set(0, 16'h4000, 16'h1000, 16'd0, 16'd0, 16'd2, 16'h3);
        wb = nwr; rb = nrd;
        cfg_write(4'h6, 16'h1);
        wait_idle("R10 zero");
        check(nwr == wb && nrd == rb, "R10 no access", nwr - wb, 0);
        check(done_irq == 2'b11, "R10 done bit A", done_irq, 3);
        check(last_set == 1'b0, "R10 last_set", last_set, 0);
    endtask

    task automatic test_irq_clear();
        cfg_write(4'h7, 16'h0);
        @(negedge clk);
        check(done_irq == 2'b11, "R7 write 0 no effect", done_irq, 3);
        cfg_write(4'h7, 16'h1);
        @(negedge clk);
        check(done_irq == 2'b10, "R7 clear A only", done_irq, 2);
        cfg_write(4'h7, 16'h2);
        @(negedge clk);
        check(done_irq == 2'b00, "R7 clear B", done_irq, 0);
    endtask

    task automatic test_start_ignored();
        int wb, rb;
        bit quiet;
        per_req = 1'b0;
        prog_set(0, 16'h4000, 16'h1000, 16'd2, 16'd0, 16'd2, 16'h3);
        wb = nwr; rb = nrd;
        cfg_write(4'h6, 16'h1);
        quiet = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (mem_req) quiet = 1'b0;
        end
        check(quiet, "R8 no access without request", nrd - rb, 0);
        cfg_write(4'h6, 16'h3);
        per_req = 1'b1;
        wait_idle("R11 ignore");
        check(nwr - wb == 2, "R11 start ignored count", nwr - wb, 2);
        check(waddr[wb % 256] == 16'h1000, "R11 original set kept", waddr[wb % 256], 16'h1000);
        check(done_irq == 2'b01, "R11 only A done", done_irq, 1);
        check(last_set == 1'b0, "R11 last_set A", last_set, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_single_block();
        test_pingpong_stall();
        test_row_skip();
        test_count_zero();
        test_irq_clear();
        test_start_ignored();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule